// File: doc/BRIEF.md
# Power-of-Two I/Q Gain Stage with Frame-Based Automatic Gain Control

This block scales a stream of 16-bit signed I/Q samples by a power of two before they reach a pulse-compression filter. The gain is a 4-bit code. Its top bit selects the direction and its low three bits give a shift count. The host can fix the gain directly. The block can also run its own control loop, which moves the gain only at frame boundaries.

While samples pass through, the block measures each frame. It counts the samples that hit the 16-bit rails and tracks the largest sample magnitude. At each frame pulse it latches both results as status. In automatic mode it also uses them to adjust the gain. A frame with any clipping lowers the gain by a programmable step. A weak frame raises the gain by another step, but only after a programmable number of clip-free frames have passed. When automatic mode is off and the code is zero, samples pass through unchanged with one cycle of delay.

Top module: `shift_gain_agc`

## Requirements
- R1: Gain code bit 3 selects direction (0 = multiply by 2^n, 1 = arithmetic right shift by n) and bits 2:0 give n in 0..7. The output sample is the input scaled this way.
- R2: With automatic mode off and a code of 0000 or 1000, each output sample equals its input sample.
- R3: A left-shifted result outside the 16-bit signed range is replaced by +32767 or -32768, according to its sign.
- R4: `out_valid` is `in_valid` delayed by exactly one clock, and the output data belongs to that same sample.
- R5: At each frame pulse, `stat_clip_cnt` takes the number of valid samples in the frame just ended where the I or Q lane was clamped. The count saturates at 255, and the count for the next frame restarts at zero.
- R6: At each frame pulse, `stat_peak` takes bits 14:7 of the frame's largest output magnitude max(|I|,|Q|), where |-32768| is taken as 32767.
- R7: With automatic mode off, `stat_gain` equals the manual code, with 1000 reported as 0000, and clipping has no effect on the gain.
- R8: In automatic mode the gain changes only on a frame pulse. A frame with at least one clipped sample lowers the gain by `agc_attack`, clamped at -7 (code 1111). Changes to the manual code are ignored.
- R9: In automatic mode a clip-free frame whose peak status value is below `agc_target` raises the gain by `agc_decay`, clamped at +7, provided the hold-off count is zero. A frame that is not weak leaves the gain unchanged.
- R10: A clipping frame loads the hold-off count from `agc_holdoff`. Each later clip-free frame pulse decrements a nonzero count instead of raising the gain.
- R11: When automatic mode is enabled, the loop starts from the gain that the manual code was giving.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample qualifier |
| in_i | input | 16 | Input I sample, signed |
| in_q | input | 16 | Input Q sample, signed |
| gain_code | input | 4 | Manual gain code {dir, shift[2:0]} |
| auto_en | input | 1 | 1 = automatic gain control |
| agc_target | input | 8 | Peak status value below which a frame is weak |
| agc_attack | input | 4 | Gain decrease after a clipping frame |
| agc_decay | input | 4 | Gain increase after a weak frame |
| agc_holdoff | input | 4 | Clip-free frames required before a gain increase |
| frame_tick | input | 1 | One-cycle frame boundary pulse |
| out_valid | output | 1 | Output sample qualifier |
| out_i | output | 16 | Scaled I sample, signed |
| out_q | output | 16 | Scaled Q sample, signed |
| stat_clip_cnt | output | 8 | Clipped sample count of the last frame |
| stat_peak | output | 8 | Peak magnitude bits 14:7 of the last frame |
| stat_gain | output | 4 | Effective gain as a code |

## Verification
An output sample and its valid appear at the first rising edge after the input is presented. The bench drives on the falling edge and compares at the next falling edge. The frame statistics and any automatic gain step take effect at the edge that samples the frame pulse. The bench inserts an idle cycle before each pulse so that no sample sits on the boundary. It reads the status one half-cycle after that edge, and it sends the next sample only after that point, so each sample is scaled by the gain that followed the boundary. `stat_gain` is combinational from the gain register and the manual code, so the bench checks it in the same cycle that it changes the controls.

// File: rtl/sgagc_pkg.sv
package sgagc_pkg;
  localparam int GAIN_LIM = 7;

  typedef logic signed [3:0] gain_t;
  typedef logic [3:0]        code_t;

  function automatic gain_t code_to_gain(code_t c);
    gain_t m;
    m = $signed({1'b0, c[2:0]});
    return c[3] ? -m : m;
  endfunction

  function automatic code_t gain_to_code(gain_t g);
    code_t c;
    if (g[3]) c = {1'b1, 3'(-g[2:0])};
    else      c = {1'b0, g[2:0]};
    return c;
  endfunction

  function automatic logic [2:0] gain_amount(gain_t g);
    return g[3] ? 3'(-g[2:0]) : g[2:0];
  endfunction
endpackage

// File: rtl/sgagc_shift.sv
module sgagc_shift
  import sgagc_pkg::*;
#(
  parameter int DW = 16
) (
  input  gain_t                 gain,
  input  logic signed [DW-1:0]  din,
  output logic signed [DW-1:0]  dout,
  output logic                  clip
);
  localparam int MAXS = GAIN_LIM;
  localparam int WW   = DW + MAXS;
  localparam logic signed [DW-1:0] MAXV = {1'b0, {(DW-1){1'b1}}};
  localparam logic signed [DW-1:0] MINV = {1'b1, {(DW-1){1'b0}}};

  logic [2:0]           amt;
  logic signed [WW-1:0] ext;
  logic signed [WW-1:0] up;
  logic [MAXS:0]        hi;

  always_comb begin
    amt  = gain_amount(gain);
    ext  = {{MAXS{din[DW-1]}}, din};
    up   = ext <<< amt;
    hi   = up[WW-1:DW-1];
    clip = 1'b0;
    if (gain[3]) begin
      dout = din >>> amt;
    end else if (!((&hi) || !(|hi))) begin
      clip = 1'b1;
      dout = up[WW-1] ? MINV : MAXV;
    end else begin
      dout = up[DW-1:0];
    end
  end
endmodule

// File: rtl/sgagc_meter.sv
module sgagc_meter #(
  parameter int DW = 16,
  parameter int CW = 8,
  parameter int PW = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sample_valid,
  input  logic signed [DW-1:0] res_i,
  input  logic signed [DW-1:0] res_q,
  input  logic                 sample_clip,
  input  logic                 frame_tick,
  output logic                 frame_clipped,
  output logic [PW-1:0]        frame_peak_hi,
  output logic [CW-1:0]        stat_clip,
  output logic [PW-1:0]        stat_peak
);
  localparam int MW = DW - 1;
  localparam logic signed [DW-1:0] MINV = {1'b1, {(DW-1){1'b0}}};

  logic [CW-1:0] acc_clip_q, acc_clip_d, stat_clip_d;
  logic [MW-1:0] acc_peak_q, acc_peak_d;
  logic [PW-1:0] stat_peak_d;
  logic [MW-1:0] mag_i, mag_q, smag;

  function automatic logic [MW-1:0] mag_of(logic signed [DW-1:0] x);
    if (!x[DW-1])   return x[MW-1:0];
    if (x == MINV)  return {MW{1'b1}};
    return (~x[MW-1:0]) + 1'b1;
  endfunction

  always_comb begin
    mag_i       = mag_of(res_i);
    mag_q       = mag_of(res_q);
    smag        = (mag_i > mag_q) ? mag_i : mag_q;
    acc_clip_d  = acc_clip_q;
    acc_peak_d  = acc_peak_q;
    stat_clip_d = stat_clip;
    stat_peak_d = stat_peak;
    if (frame_tick) begin
      stat_clip_d = acc_clip_q;
      stat_peak_d = acc_peak_q[MW-1 -: PW];
      acc_clip_d  = CW'(sample_valid && sample_clip);
      acc_peak_d  = sample_valid ? smag : '0;
    end else if (sample_valid) begin
      if (sample_clip && !(&acc_clip_q)) acc_clip_d = acc_clip_q + 1'b1;
      if (smag > acc_peak_q)             acc_peak_d = smag;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_clip_q <= '0;
      acc_peak_q <= '0;
      stat_clip  <= '0;
      stat_peak  <= '0;
    end else begin
      acc_clip_q <= acc_clip_d;
      acc_peak_q <= acc_peak_d;
      stat_clip  <= stat_clip_d;
      stat_peak  <= stat_peak_d;
    end
  end

  assign frame_clipped = |acc_clip_q;
  assign frame_peak_hi = acc_peak_q[MW-1 -: PW];

  AST_CLIP_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_tick |=> acc_clip_q >= $past(acc_clip_q)); // R5
endmodule

// File: rtl/sgagc_ctrl.sv
module sgagc_ctrl
  import sgagc_pkg::*;
#(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          auto_en,
  input  code_t         manual_code,
  input  logic [PW-1:0] target,
  input  logic [3:0]    attack,
  input  logic [3:0]    decay,
  input  logic [3:0]    holdoff,
  input  logic          frame_tick,
  input  logic          frame_clipped,
  input  logic [PW-1:0] frame_peak_hi,
  output gain_t         gain_eff
);
  localparam gain_t GMAX = 4'sd7;
  localparam gain_t GMIN = -4'sd7;

  gain_t             gain_q, gain_d;
  logic [3:0]        hold_q, hold_d;
  logic signed [5:0] g_ext, g_dn, g_up;

  always_comb begin
    g_ext  = {{2{gain_q[3]}}, gain_q};
    g_dn   = g_ext - $signed({2'b00, attack});
    g_up   = g_ext + $signed({2'b00, decay});
    gain_d = gain_q;
    hold_d = hold_q;
    if (!auto_en) begin
      gain_d = code_to_gain(manual_code);
      hold_d = '0;
    end else if (frame_tick) begin
      if (frame_clipped) begin
        gain_d = (g_dn < -6'sd7) ? GMIN : g_dn[3:0];
        hold_d = holdoff;
      end else if (hold_q != '0) begin
        hold_d = hold_q - 1'b1;
      end else if (frame_peak_hi < target) begin
        gain_d = (g_up > 6'sd7) ? GMAX : g_up[3:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gain_q <= '0;
      hold_q <= '0;
    end else begin
      gain_q <= gain_d;
      hold_q <= hold_d;
    end
  end

  assign gain_eff = auto_en ? gain_q : code_to_gain(manual_code);

  AST_GAIN_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    gain_q >= GMIN); // R8
  AST_GAIN_FRAME_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    auto_en && !frame_tick |=> $stable(gain_q)); // R8
  AST_HOLDOFF_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    auto_en && frame_tick && !frame_clipped && hold_q != '0 |=> $stable(gain_q)); // R10
endmodule

// File: rtl/shift_gain_agc.sv
module shift_gain_agc
  import sgagc_pkg::*;
#(
  parameter int DW = 16,
  parameter int CW = 8,
  parameter int PW = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_i,
  input  logic signed [DW-1:0] in_q,
  input  logic [3:0]           gain_code,
  input  logic                 auto_en,
  input  logic [PW-1:0]        agc_target,
  input  logic [3:0]           agc_attack,
  input  logic [3:0]           agc_decay,
  input  logic [3:0]           agc_holdoff,
  input  logic                 frame_tick,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_i,
  output logic signed [DW-1:0] out_q,
  output logic [CW-1:0]        stat_clip_cnt,
  output logic [PW-1:0]        stat_peak,
  output logic [3:0]           stat_gain
);
  localparam int LANES = 2;

  logic [1:0]           rst_sync;
  logic                 rst_s;
  gain_t                gain_eff;
  logic signed [DW-1:0] lane_in  [LANES];
  logic signed [DW-1:0] lane_out [LANES];
  logic [LANES-1:0]     lane_clip;
  logic                 frame_clipped;
  logic [PW-1:0]        frame_peak_hi;
  logic                 valid_d;
  logic signed [DW-1:0] oi_d, oq_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_s = rst_sync[1];

  assign lane_in[0] = in_i;
  assign lane_in[1] = in_q;

  for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
    sgagc_shift #(.DW(DW)) u_shift (
      .gain (gain_eff),
      .din  (lane_in[ln]),
      .dout (lane_out[ln]),
      .clip (lane_clip[ln])
    );
  end

  sgagc_meter #(.DW(DW), .CW(CW), .PW(PW)) u_meter (
    .clk           (clk),
    .rst_n         (rst_s),
    .sample_valid  (in_valid),
    .res_i         (lane_out[0]),
    .res_q         (lane_out[1]),
    .sample_clip   (|lane_clip),
    .frame_tick    (frame_tick),
    .frame_clipped (frame_clipped),
    .frame_peak_hi (frame_peak_hi),
    .stat_clip     (stat_clip_cnt),
    .stat_peak     (stat_peak)
  );

  sgagc_ctrl #(.PW(PW)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_s),
    .auto_en       (auto_en),
    .manual_code   (gain_code),
    .target        (agc_target),
    .attack        (agc_attack),
    .decay         (agc_decay),
    .holdoff       (agc_holdoff),
    .frame_tick    (frame_tick),
    .frame_clipped (frame_clipped),
    .frame_peak_hi (frame_peak_hi),
    .gain_eff      (gain_eff)
  );

  always_comb begin
    valid_d = in_valid;
    oi_d    = in_valid ? lane_out[0] : out_i;
    oq_d    = in_valid ? lane_out[1] : out_q;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      out_valid <= 1'b0;
      out_i     <= '0;
      out_q     <= '0;
    end else begin
      out_valid <= valid_d;
      out_i     <= oi_d;
      out_q     <= oq_d;
    end
  end

  assign stat_gain = gain_to_code(gain_eff);

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_s)
    in_valid |=> out_valid); // R4
  AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_s)
    !in_valid |=> !out_valid); // R4
  AST_UNITY_PASS: assert property (@(posedge clk) disable iff (!rst_s)
    in_valid && !auto_en && gain_code[2:0] == 3'd0
      |=> out_i == $past(in_i) && out_q == $past(in_q)); // R2
endmodule

// File: tb/shift_gain_agc_tb_top.sv
module shift_gain_agc_tb_top;
  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              in_valid = 1'b0;
  logic signed [15:0] in_i = '0, in_q = '0;
  logic [3:0]        gain_code = 4'd0;
  logic              auto_en = 1'b0;
  logic [7:0]        agc_target = 8'd0;
  logic [3:0]        agc_attack = 4'd0, agc_decay = 4'd0, agc_holdoff = 4'd0;
  logic              frame_tick = 1'b0;
  logic              out_valid;
  logic signed [15:0] out_i, out_q;
  logic [7:0]        stat_clip_cnt, stat_peak;
  logic [3:0]        stat_gain;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  shift_gain_agc dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
    .gain_code(gain_code), .auto_en(auto_en), .agc_target(agc_target),
    .agc_attack(agc_attack), .agc_decay(agc_decay), .agc_holdoff(agc_holdoff),
    .frame_tick(frame_tick), .out_valid(out_valid), .out_i(out_i), .out_q(out_q),
    .stat_clip_cnt(stat_clip_cnt), .stat_peak(stat_peak), .stat_gain(stat_gain)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
      report();
    end
  end

  function automatic int ref_scale(int x, logic [3:0] code);
    int a = int'(code[2:0]);
    int v;
    if (code[3]) v = x >>> a;
    else begin
      v = x * (1 << a);
      if (v > 32767)  v = 32767;
      if (v < -32768) v = -32768;
    end
    return v;
  endfunction

  function automatic bit ref_clip(int x, logic [3:0] code);
    int v = x * (1 << int'(code[2:0]));
    return !code[3] && (v > 32767 || v < -32768);
  endfunction

  task automatic send(input int i, input int q);
    @(negedge clk);
    in_valid = 1'b1;
    in_i = 16'(i);
    in_q = 16'(q);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk);
    frame_tick = 1'b1;
    @(negedge clk);
    frame_tick = 1'b0;
  endtask

  initial begin
    int vals[15] = '{0, 1, -1, 5, -5, 100, -100, 4095, -4096, 4096, -4097, 32767, -32768, 1234, -1234};
    int ei, eq;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    chk(out_valid == 1'b0, "R4 reset valid", int'(out_valid), 0);
    chk(stat_clip_cnt == 8'd0, "R5 reset clip", int'(stat_clip_cnt), 0);
    chk(stat_peak == 8'd0, "R6 reset peak", int'(stat_peak), 0);
    chk(stat_gain == 4'd0, "R7 reset gain", int'(stat_gain), 0);

    // Manual sweep over every code and sample pattern: R1, R2, R3, R4, R7
    for (int c = 0; c < 16; c++) begin
      gain_code = 4'(c);
      @(negedge clk);
      chk(stat_gain == ((c == 8) ? 4'd0 : 4'(c)), "R7 manual code", int'(stat_gain), (c == 8) ? 0 : c);
      for (int k = 0; k < 15; k++) begin
        send(vals[k], vals[14-k]);
        ei = ref_scale(vals[k], 4'(c));
        eq = ref_scale(vals[14-k], 4'(c));
        chk(out_valid == 1'b1, "R4 valid after one cycle", int'(out_valid), 1);
        if (ref_clip(vals[k], 4'(c)))
          chk(int'(out_i) == ei, "R3 clamp I", int'(out_i), ei);
        else if (c == 0 || c == 8)
          chk(int'(out_i) == ei, "R2 pass I", int'(out_i), ei);
        else
          chk(int'(out_i) == ei, "R1 shift I", int'(out_i), ei);
        chk(int'(out_q) == eq, "R1 shift Q", int'(out_q), eq);
      end
      @(negedge clk);
      chk(out_valid == 1'b0, "R4 valid drop", int'(out_valid), 0);
      tick();
    end

    // R5: saturating clip count, per-frame restart; R7 manual ignores clipping
    gain_code = 4'b0111;
    agc_attack = 4'd3;
    tick();
    for (int n = 0; n < 300; n++) send(1000, 0);
    tick();
    chk(stat_clip_cnt == 8'd255, "R5 saturate", int'(stat_clip_cnt), 255);
    chk(stat_gain == 4'b0111, "R7 manual unaffected by clip", int'(stat_gain), 7);
    for (int n = 0; n < 3; n++) send(0, -1000);
    for (int n = 0; n < 10; n++) send(2, 2);
    tick();
    chk(stat_clip_cnt == 8'd3, "R5 count three", int'(stat_clip_cnt), 3);
    tick();
    chk(stat_clip_cnt == 8'd0, "R5 empty frame", int'(stat_clip_cnt), 0);

    // R6: peak magnitude status
    gain_code = 4'b0000;
    send(5000, -20000);
    send(100, 3);
    tick();
    chk(stat_peak == 8'd156, "R6 peak", int'(stat_peak), 156);
    send(-32768, 0);
    tick();
    chk(stat_peak == 8'd255, "R6 most negative", int'(stat_peak), 255);
    tick();
    chk(stat_peak == 8'd0, "R6 empty frame", int'(stat_peak), 0);

    // Automatic control
    agc_target = 8'd100; agc_attack = 4'd3; agc_decay = 4'd1; agc_holdoff = 4'd2;
    gain_code = 4'b0010;
    @(negedge clk);
    auto_en = 1'b1;
    @(negedge clk);
    chk(stat_gain == 4'b0010, "R11 start from manual", int'(stat_gain), 2);
    send(20000, 0);
    chk(int'(out_i) == 32767, "R3 clamp in auto", int'(out_i), 32767);
    tick();
    chk(stat_gain == 4'b1001, "R8 attack step", int'(stat_gain), 9);
    send(10, -10);
    chk(int'(out_i) == 5 && int'(out_q) == -5, "R1 auto gain applied", int'(out_i), 5);
    tick();
    chk(stat_gain == 4'b1001, "R10 holdoff frame 1", int'(stat_gain), 9);
    send(10, -10);
    tick();
    chk(stat_gain == 4'b1001, "R10 holdoff frame 2", int'(stat_gain), 9);
    send(10, -10);
    tick();
    chk(stat_gain == 4'b0000, "R9 decay after holdoff", int'(stat_gain), 0);
    gain_code = 4'b0111;
    send(10, 0);
    chk(int'(out_i) == 10, "R8 manual code ignored", int'(out_i), 10);
    chk(stat_gain == 4'b0000, "R8 manual code ignored status", int'(stat_gain), 0);
    tick();
    chk(stat_gain == 4'b0001, "R9 decay step", int'(stat_gain), 1);
    agc_decay = 4'd15;
    tick();
    chk(stat_gain == 4'b0111, "R9 clamp at +7", int'(stat_gain), 7);
    agc_target = 8'd0;
    send(1, 1);
    chk(int'(out_i) == 128, "R1 auto +7", int'(out_i), 128);
    tick();
    chk(stat_gain == 4'b0111, "R9 not weak no change", int'(stat_gain), 7);
    agc_attack = 4'd15; agc_holdoff = 4'd0;
    send(1000, 0);
    tick();
    chk(stat_gain == 4'b1111, "R8 clamp at -7", int'(stat_gain), 15);
    send(-32768, 32767);
    chk(int'(out_i) == -256 && int'(out_q) == 255, "R1 auto -7", int'(out_i), -256);

    report();
  end
endmodule